// File: doc/BRIEF.md
# Waveform Synthesizer Command Register File

This block is the command side of a direct digital synthesizer. It takes 16-bit command words, one per cycle when a valid strobe is high, and sorts them by their top bits into a control register, two 28-bit frequency tuning words and two 12-bit phase offsets. A 28-bit phase accumulator steps on every master clock by the selected tuning word. Its top 12 bits, plus the selected phase offset, pass through a fixed-length pipeline to the output code.

A software reset bit in the control register holds the accumulator at zero and forces the output code to midscale. It leaves the stored tuning and offset words untouched. A tuning word can be written in one of two ways. Two consecutive writes can carry the low half and then the high half, with the pair committed at once. A single write can instead replace the half chosen by a control bit.

Top module: `wavegen_regfile`

## Requirements
- R1: After the hardware reset `rst_n`, the control register reads 0x0100 (only the software reset bit 8 set) and the output code reads midscale 0x800.
- R2: While control bit 8 is set, the output code is 0x800 and the accumulator is held at zero. Setting the bit again while running returns the output to 0x800 at once.
- R3: With control bit 13 set, the first write to a frequency address is staged and leaves that register unchanged. The next write to the same address commits {second[13:0], first[13:0]} as the full 28-bit word.
- R4: Command bits [15:14] decode as 00 for control (bits [13:0] stored), 01 for frequency word 0 and 10 for frequency word 1.
- R5: Command bits [15:13] = 110 write phase offset 0 and 111 write phase offset 1, taking data from bits [11:0]. Bit 12 is ignored.
- R6: With control bit 13 clear, a frequency write replaces only bits [13:0] when control bit 12 is 0, and only bits [27:14] when it is 1.
- R7: Setting or clearing the software reset bit leaves both frequency words and both phase offsets unchanged. Without a write, no stored register changes.
- R8: Count the clock edges from the one that stores a control word with bit 8 clear. The output stays 0x800 through the 7th of those edges. After the 8th, it equals the selected phase offset.
- R9: Each clock, the accumulator adds the selected frequency word modulo 2^28. After release edge n (n >= 8), the output is (((n-8)·F) mod 2^28)[27:16] + P, taken mod 4096.
- R10: Control bit 11 selects frequency word 1 (0 selects word 0), and control bit 10 selects phase offset 1 (0 selects offset 0).
- R11: A control write discards a staged low half. The next frequency write is then treated as a new low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word |
| out_code | output | 12 | Output phase code, 0x800 at midscale |
| ctrl_q | output | 14 | Control register contents |
| freq0_q | output | 28 | Frequency word 0 |
| freq1_q | output | 28 | Frequency word 1 |
| phase0_q | output | 12 | Phase offset 0 |
| phase1_q | output | 12 | Phase offset 1 |

## Verification
A control write can land while a low half-word is still staged. In that one cycle it both changes the write mode and must drop the staged half. The bench provokes this by staging a low half, writing control, and then sending a new low/high pair. It judges the result by the committed word, which must be built only from the pair sent after the control write. The release of the reset bit also coincides with the first accumulator step. This is judged by comparing every output code, cycle by cycle, against a scoreboard computed from the requirements.

// File: rtl/wavegen_regfile.sv
module wavegen_regfile #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  output logic [PH_W-1:0]  out_code,
  output logic [13:0]      ctrl_q,
  output logic [ACC_W-1:0] freq0_q,
  output logic [ACC_W-1:0] freq1_q,
  output logic [PH_W-1:0]  phase0_q,
  output logic [PH_W-1:0]  phase1_q
);
  localparam int HALF = ACC_W / 2;
  localparam logic [PH_W-1:0] MID = PH_W'(1) << (PH_W - 1);

  logic [ACC_W-1:0] freq_q [2];
  logic [PH_W-1:0]  phase_q [2];
  logic [HALF-1:0]  stage_q;
  logic [1:0]       pend_q;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  pipe_q [LAT];

  wire is_ctrl = cmd_valid && cmd_word[15:14] == 2'b00;
  wire [1:0] is_f = {cmd_valid && cmd_word[15:14] == 2'b10,
                     cmd_valid && cmd_word[15:14] == 2'b01};
  wire [1:0] is_p = {cmd_valid && cmd_word[15:13] == 3'b111,
                     cmd_valid && cmd_word[15:13] == 3'b110};

  wire two_wr  = ctrl_q[13];
  wire hi_sel  = ctrl_q[12];
  wire rst_bit = ctrl_q[8];
  wire [ACC_W-1:0] f_sel = freq_q[ctrl_q[11]];
  wire [PH_W-1:0]  p_sel = phase_q[ctrl_q[10]];
  wire [HALF-1:0]  data  = cmd_word[HALF-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= 14'h0100;
    else if (is_ctrl) ctrl_q <= cmd_word[13:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q  <= '0;
      stage_q <= '0;
    end else if (is_ctrl) begin
      pend_q <= '0;
    end else begin
      for (int k = 0; k < 2; k++)
        if (is_f[k] && two_wr) begin
          if (pend_q[k]) pend_q <= '0;
          else begin
            stage_q <= data;
            pend_q  <= 2'(1 << k);
          end
        end
    end

  always_ff @(posedge clk)
    for (int k = 0; k < 2; k++) begin
      if (is_f[k]) begin
        if (two_wr) begin
          if (pend_q[k]) freq_q[k] <= {data, stage_q};
        end else if (hi_sel) freq_q[k][ACC_W-1:HALF] <= data;
        else                 freq_q[k][HALF-1:0]     <= data;
      end
      if (is_p[k]) phase_q[k] <= cmd_word[PH_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       acc_q <= '0;
    else if (rst_bit) acc_q <= '0;
    else              acc_q <= acc_q + f_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) pipe_q[i] <= MID;
    end else begin
      pipe_q[0] <= rst_bit ? MID : acc_q[ACC_W-1 -: PH_W] + p_sel;
      for (int i = 1; i < LAT; i++) pipe_q[i] <= rst_bit ? MID : pipe_q[i-1];
    end

  assign out_code = rst_bit ? MID : pipe_q[LAT-1];
  assign freq0_q  = freq_q[0];
  assign freq1_q  = freq_q[1];
  assign phase0_q = phase_q[0];
  assign phase1_q = phase_q[1];

  AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_bit) |-> acc_q == '0); // R2
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_bit) |-> acc_q == $past(acc_q) + $past(f_sel)); // R9
  AST_NO_HALF_F0: assert property (@(posedge clk) disable iff (!rst_n)
    (is_f[0] && two_wr && !pend_q[0]) |=> $stable(freq0_q)); // R3
  AST_NO_HALF_F1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_f[1] && two_wr && !pend_q[1]) |=> $stable(freq1_q)); // R3
  AST_REGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(freq0_q) && $stable(freq1_q) && $stable(phase0_q) && $stable(phase1_q)); // R7
  AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_q)); // R11
  AST_RELEASE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_bit) |-> out_code == MID); // R8
endmodule

// File: tb/wavegen_regfile_bench.sv
module wavegen_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [15:0] cmd_word = '0;
  logic [11:0] out_code, phase0_q, phase1_q;
  logic [13:0] ctrl_q;
  logic [27:0] freq0_q, freq1_q;

  wavegen_regfile u_wavegen_regfile (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .out_code(out_code), .ctrl_q(ctrl_q), .freq0_q(freq0_q), .freq1_q(freq1_q),
    .phase0_q(phase0_q), .phase1_q(phase1_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          kind;
    logic [27:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  task automatic check(int kind, logic [27:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    -> sample_ev;
  endtask

  function automatic logic [27:0] observe(int kind);
    case (kind)
      0: return 28'(out_code);
      1: return freq0_q;
      2: return freq1_q;
      3: return 28'(phase0_q);
      4: return 28'(phase1_q);
      default: return 28'(ctrl_q);
    endcase
  endfunction

  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [27:0] got;
      it  = q.pop_front();
      got = observe(it.kind);
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic run_out(logic [27:0] f, logic [11:0] p, int cycles, string req_lat, string req_acc);
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      if (k < 8) check(0, 28'h800, req_lat);
      else begin
        logic [27:0] a;
        logic [11:0] e;
        a = 28'(f * 28'(k - 8));
        e = a[27:16] + p;
        check(0, 28'(e), (k == 8) ? req_lat : req_acc);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [27:0] F0 = 28'h0123456;
  localparam logic [27:0] F1 = 28'h0E00ABC;

  initial begin
    logic [27:0] keep0, keep1;
    repeat (3) @(negedge clk);
    check(5, 28'h0100, "R1");
    check(0, 28'h800, "R1");
    rst_n = 1;

    send(16'h2100);
    check(5, 28'h2100, "R4");
    send(16'h4000 | 16'h10C7);
    send(16'h4001);
    check(1, {14'h1, 14'h10C7}, "R3");
    send(16'h4ABC);
    check(1, {14'h1, 14'h10C7}, "R3");
    send(16'h4012);
    check(1, {14'h12, 14'h0ABC}, "R3");
    send(16'h8000 | 16'h3FFF);
    send(16'h8003);
    check(2, {14'h3, 14'h3FFF}, "R4");

    send(16'hD123);
    check(3, 28'h123, "R5");
    send(16'hE456);
    check(4, 28'h456, "R5");

    send(16'h0100);
    send(16'h4000 | 16'h2AAA);
    check(1, {14'h12, 14'h2AAA}, "R6");
    send(16'h1100);
    check(5, 28'h1100, "R4");
    send(16'h4155);
    check(1, {14'h155, 14'h2AAA}, "R6");

    keep0 = freq0_q; keep1 = freq1_q;
    send(16'h0000);
    send(16'h2100);
    check(1, keep0, "R7");
    check(2, keep1, "R7");
    check(3, 28'h123, "R7");
    check(4, 28'h456, "R7");

    send(16'h4000 | 16'h1111);
    send(16'h2100);
    send(16'h4000 | 16'(F0[13:0]));
    send(16'h4000 | 16'(F0[27:14]));
    check(1, F0, "R11");
    send(16'h8000 | 16'(F1[13:0]));
    send(16'h8000 | 16'(F1[27:14]));
    check(2, F1, "R3");

    send(16'h2000);
    run_out(F0, 12'h123, 24, "R8", "R9");

    send(16'h2100);
    check(0, 28'h800, "R2");
    repeat (3) @(negedge clk);
    check(0, 28'h800, "R2");

    send(16'h2D00);
    send(16'h2C00);
    run_out(F1, 12'h456, 20, "R10", "R10");

    @(negedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule